// File: doc/BRIEF.md
# Serial Input Delay Calibrator

This block picks the sampling delay for a serial input link during bring-up. After a start pulse it steps the 2-bit delay select through its four settings, 0 to 3 (nominally 0, 2, 4 and 6 ns of input delay), in ascending order. For each setting it issues one read of a fixed test register through a request/response port and compares the returned word with the expected pattern 0x5AA5. The per-setting outcomes form a 4-bit pass mask.

When all four trials are done, a fixed 16-entry table turns the pass mask into the chosen delay, which sits near the middle of the passing window. Masks whose passing settings are empty or not adjacent have no table entry. For such a mask the block raises an error and puts back the delay that was in force before calibration. A one-cycle done pulse marks the end, and the error flag is valid with it. The read transaction itself and the delay line lie outside the block.

Top module: `sidly_cal`

## Requirements
- R1: Out of reset, dly_sel is 0 and rd_req, done, err and pass_mask are all 0.
- R2: A start pulse while idle begins calibration. Trial i (i = 0, 1, 2, 3, in that order) drives dly_sel to i one cycle before its rd_req. rd_req is high for exactly one cycle per trial. The next trial's dly_sel update follows in the cycle after the previous trial resolves.
- R3: A trial passes only when its response data equals 0x5AA5 exactly. pass_mask bit i holds the outcome of trial i.
- R4: For a request in cycle c, a response is taken if rd_rsp_valid is high in any of cycles c+1 through c+1+tmo_limit. If no response arrives in that window, the trial fails and resolves in cycle c+1+tmo_limit.
- R5: The pass mask selects the final delay. The valid entries are 0001→0, 0010→1, 0011→0, 0100→2, 0110→1, 0111→1, 1000→3, 1100→3, 1110→2 and 1111→1; on these, dly_sel takes that value and err is 0.
- R6: Every other mask (0000, 0101, 1001, 1010, 1011, 1101) sets err to 1 and returns dly_sel to the value it held just before start.
- R7: done is a one-cycle pulse two cycles after the last trial resolves. err is updated in that same cycle and holds until the next start.
- R8: A start pulse during a calibration in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin calibration (pulse) |
| tmo_limit | input | TW | Response wait limit in cycles |
| rd_req | output | 1 | One-cycle request to read the test register |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_data | input | DW | Read response data |
| dly_sel | output | 2 | Delay select driven to the delay line |
| pass_mask | output | 4 | Per-setting pass results |
| done | output | 1 | Calibration finished (pulse) |
| err | output | 1 | Pass window empty or not contiguous |

## Verification
The assertions assume that tmo_limit stays stable during a calibration and that responses come only while a trial is waiting, never in the same cycle as rd_req. The stimulus changes tmo_limit only between runs. Each response is placed a set number of cycles after its request and falls inside the window, or is withheld completely. No late response is left to spill into the next trial. Latencies cover the first and the last accepted cycle of the window, a missing response, and near-miss data words.

// File: rtl/sidly_cal.sv
module sidly_cal #(
  parameter int          DW      = 16,
  parameter logic [15:0] PATTERN = 16'h5AA5,
  parameter int          TW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] tmo_limit,
  output logic          rd_req,
  input  logic          rd_rsp_valid,
  input  logic [DW-1:0] rd_rsp_data,
  output logic [1:0]    dly_sel,
  output logic [3:0]    pass_mask,
  output logic          done,
  output logic          err
);
  localparam int NSET = 4;
  localparam logic [1:0] LAST = 2'(NSET - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_REQ, S_WAIT, S_DECIDE} st_t;

  st_t           st;
  logic [1:0]    idx, sel, keep_sel;
  logic [TW-1:0] timer;
  logic [3:0]    mask;
  logic          done_q, err_q;
  logic [2:0]    choice;

  function automatic logic [2:0] pick(input logic [3:0] m);
    case (m)
      4'd1:    return 3'b100;
      4'd2:    return 3'b101;
      4'd3:    return 3'b100;
      4'd4:    return 3'b110;
      4'd6:    return 3'b101;
      4'd7:    return 3'b101;
      4'd8:    return 3'b111;
      4'd12:   return 3'b111;
      4'd14:   return 3'b110;
      4'd15:   return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  assign choice    = pick(mask);
  assign rd_req    = (st == S_REQ);
  assign dly_sel   = sel;
  assign pass_mask = mask;
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      sel      <= '0;
      keep_sel <= '0;
      timer    <= '0;
      mask     <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          idx      <= '0;
          mask     <= '0;
          keep_sel <= sel;
          sel      <= '0;
          err_q    <= 1'b0;
          st       <= S_SETTLE;
        end
        S_SETTLE: st <= S_REQ;
        S_REQ: begin
          timer <= '0;
          st    <= S_WAIT;
        end
        S_WAIT: begin
          if (rd_rsp_valid || timer == tmo_limit) begin
            mask[idx] <= rd_rsp_valid && (rd_rsp_data == DW'(PATTERN));
            if (idx == LAST) st <= S_DECIDE;
            else begin
              idx <= idx + 2'd1;
              sel <= idx + 2'd1;
              st  <= S_SETTLE;
            end
          end else begin
            timer <= timer + 1'b1;
          end
        end
        S_DECIDE: begin
          done_q <= 1'b1;
          st     <= S_IDLE;
          if (choice[2]) begin
            sel   <= choice[1:0];
            err_q <= 1'b0;
          end else begin
            sel   <= keep_sel;
            err_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  a_r2_sel_settled: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> $stable(dly_sel));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (timer <= tmo_limit));
  a_r5_success_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (pass_mask != 4'd0));
  a_r8_no_req_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);
endmodule

// File: tb/sidly_cal_bench.sv
module sidly_cal_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  tmo_limit = 8'd4;
  logic        rd_req;
  logic        rd_rsp_valid = 1'b0;
  logic [15:0] rd_rsp_data = 16'hFFFF;
  logic [1:0]  dly_sel;
  logic [3:0]  pass_mask;
  logic        done, err;

  int errors = 0, checks = 0;
  bit finished = 0;

  int          lat[4];
  logic [15:0] dat[4];
  int          busy_at;
  int          prev_sel = 0, prev_err = 0;
  int          ptab[16] = '{-1, 0, 1, 0, 2, -1, 1, 1, 3, -1, -1, -1, 3, -1, 2, 1};

  always #2.5 clk = ~clk;

  sidly_cal u_sidly_cal (
    .clk(clk), .rst_n(rst_n), .start(start), .tmo_limit(tmo_limit),
    .rd_req(rd_req), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .dly_sel(dly_sel), .pass_mask(pass_mask), .done(done), .err(err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_cal(input int lim);
    int reqc[4], rspc[4];
    int s, m, fin_sel, fin_err, last;
    s = 0; m = 0;
    tmo_limit = 8'(lim);
    for (int i = 0; i < 4; i++) begin
      reqc[i] = s + 2;
      if (lat[i] >= 1 && lat[i] <= lim + 1) begin
        rspc[i] = reqc[i] + lat[i];
        s = rspc[i];
        if (dat[i] == 16'h5AA5) m |= (1 << i);
      end else begin
        rspc[i] = -1;
        s = reqc[i] + 1 + lim;
      end
    end
    last = s + 2;
    fin_err = (ptab[m] < 0) ? 1 : 0;
    fin_sel = fin_err ? prev_sel : ptab[m];
    for (int c = 0; c <= last + 1; c++) begin
      int esel, eerr, ereq;
      @(negedge clk);
      ereq = 0;
      esel = prev_sel;
      for (int i = 0; i < 4; i++) begin
        if (c == reqc[i]) ereq = 1;
        if (c >= reqc[i] - 1) esel = i;
      end
      if (c == 0) esel = prev_sel;
      if (c >= last) esel = fin_sel;
      eerr = (c == 0) ? prev_err : (c >= last ? fin_err : 0);
      chk("R2 rd_req", rd_req, ereq);
      chk("R2/R5/R6 dly_sel", dly_sel, esel);
      chk("R7 done", done, (c == last) ? 1 : 0);
      chk("R6/R7 err", err, eerr);
      if (c == last) chk("R3/R4 pass_mask", pass_mask, m);
      start = (c == 0 || c == busy_at);
      rd_rsp_valid = 1'b0;
      rd_rsp_data  = 16'hFFFF;
      for (int i = 0; i < 4; i++)
        if (c == rspc[i]) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = dat[i];
        end
    end
    @(negedge clk);
    start = 1'b0; rd_rsp_valid = 1'b0;
    prev_sel = fin_sel;
    prev_err = fin_err;
    busy_at = -1;
  endtask

  task automatic set4(input int l0, l1, l2, l3, input logic [15:0] d0, d1, d2, d3);
    lat = '{l0, l1, l2, l3};
    dat = '{d0, d1, d2, d3};
  endtask

  initial begin
    busy_at = -1;
    repeat (3) @(negedge clk);
    chk("R1 dly_sel", dly_sel, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 pass_mask", pass_mask, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 R3 R5 R8: all pass, extra start mid-run ignored -> 1
    set4(1, 1, 1, 1, 16'h5AA5, 16'h5AA5, 16'h5AA5, 16'h5AA5);
    busy_at = 6;
    run_cal(4);
    // R3 R5: mask 1110 -> 2
    set4(2, 2, 2, 2, 16'h5AA4, 16'h5AA5, 16'h5AA5, 16'h5AA5);
    run_cal(4);
    // R3 R5: mask 0001 -> 0
    set4(1, 3, 1, 2, 16'h5AA5, 16'hA55A, 16'h0000, 16'hDAA5);
    run_cal(4);
    // R5: mask 1100 -> 3
    set4(1, 1, 1, 1, 16'h1234, 16'h5AA7, 16'h5AA5, 16'h5AA5);
    run_cal(4);
    // R6: empty -> err, keep 3
    set4(1, 1, 1, 1, 16'h0, 16'h0, 16'h0, 16'h0);
    run_cal(4);
    // R5: mask 0100 -> 2, clears err
    set4(1, 1, 1, 1, 16'h0, 16'h0, 16'h5AA5, 16'h0);
    run_cal(4);
    // R6: mask 1001 -> err, restore 2
    set4(1, 1, 1, 1, 16'h5AA5, 16'h0, 16'h0, 16'h5AA5);
    run_cal(4);
    // R4: limit 2, boundary latency 3 accepted, latency 4 times out -> mask 1110 -> 2
    set4(4, 3, 3, 1, 16'h5AA5, 16'h5AA5, 16'h5AA5, 16'h5AA5);
    run_cal(2);
    // R4: no response on trial 3 -> mask 0111 -> 1
    set4(3, 1, 2, 0, 16'h5AA5, 16'h5AA5, 16'h5AA5, 16'h5AA5);
    run_cal(2);
    // R4 R6: limit 0, late responses -> mask 0101 error
    set4(1, 2, 1, 0, 16'h5AA5, 16'h5AA5, 16'h5AA5, 16'h5AA5);
    run_cal(0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule